// File: doc/BRIEF.md
# Integer ALU with Relational Set Operations

This block is the integer arithmetic and logic unit of a small RISC core. It takes two operand words and a four-bit operation selector and returns one result word. It has no state. The result follows the inputs in the same cycle, so the block sits between the operand registers and the result register of the execute stage.

Apart from wrapping add and subtract and the three bitwise operations, the unit has a load-high operation. Load-high puts the lower half of operand B into the upper half of the result and fills the lower half with zeros. The unit also has six relational set operations. Each one compares the operands as signed values and returns the word 1 or the word 0.

The block does not choose between a register and a sign-extended immediate for operand B. That choice is made before the block, so immediate forms of an instruction use the same selector code as the register forms. The data width is a parameter, 32 by default, and must be even.

Top module: `int_alu_core`

## Requirements
- R1: Selector 0 (add) returns (A + B) modulo 2^W, with no trap or flag on overflow.
- R2: Selector 1 (subtract) returns (A - B) modulo 2^W, with no trap or flag on overflow.
- R3: Selector 2 returns A AND B, selector 3 returns A OR B, selector 4 returns A XOR B, each bit by bit.
- R4: Selector 5 (load-high) returns B[W/2-1:0] in bits W-1..W/2 and zeros in bits W/2-1..0. Operand A and the upper half of B have no effect on this result.
- R5: Selector 6 returns 1 when A < B and selector 7 returns 1 when A > B, both as two's-complement signed values; otherwise each returns 0.
- R6: Selector 8 returns 1 when A <= B and selector 9 returns 1 when A >= B, both signed; otherwise each returns 0.
- R7: Selector 10 returns 1 when A equals B and selector 11 returns 1 when A differs from B; otherwise each returns 0.
- R8: For selectors 6 to 11, bits W-1..1 of the result are always zero.
- R9: Selectors 12 to 15 return an all-zero result.
- R10: The result depends only on the current inputs: it settles within the cycle in which the inputs change, and no earlier input has any effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand, either a register value or an already extended immediate |
| op_sel | input | 4 | Operation selector, encoded as listed in R1 to R9 |
| result | output | DATA_W | Result word |

## Verification
Every result is due in the same cycle as its stimulus, with no register in the path. The bench drives a new operand pair and selector on each rising edge and samples the result on the following falling edge, so each check sees fully settled logic from that cycle's inputs only. One extra check changes the inputs in the middle of a cycle and reads the result a few nanoseconds later. This confirms R10: nothing is held over from the previous cycle.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_LHI = 4'd5,
    OP_SLT = 4'd6,
    OP_SGT = 4'd7,
    OP_SLE = 4'd8,
    OP_SGE = 4'd9,
    OP_SEQ = 4'd10,
    OP_SNE = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic lt;
    logic eq;
  } rel_flags_t;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum
);

  localparam logic [DATA_W-1:0] ZERO_W = '0;

  logic [DATA_W-1:0] b_inv;
  logic [DATA_W-1:0] carry_in;

  // Subtract as A + ~B + 1; carry out is dropped, giving modulo-2^W wrap.
  always_comb begin
    b_inv    = do_sub ? ~in_b : in_b;
    carry_in = ZERO_W;
    carry_in[0] = do_sub;
    sum      = in_a + b_inv + carry_in;
  end

endmodule

// File: rtl/alu_relcmp.sv
`timescale 1ns/1ps
module alu_relcmp
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output rel_flags_t        flags
);

  localparam int MSB = DATA_W - 1;

  logic signs_differ;
  logic mag_lt;

  // Signed less-than: differing signs decide alone; equal signs reduce to
  // an unsigned compare of the full words.
  always_comb begin
    signs_differ = in_a[MSB] ^ in_b[MSB];
    mag_lt       = in_a < in_b;
    flags.lt     = signs_differ ? in_a[MSB] : mag_lt;
    flags.eq     = (in_a == in_b);
  end

endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic [DATA_W-1:0] and_y,
  output logic [DATA_W-1:0] or_y,
  output logic [DATA_W-1:0] xor_y
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_y[i] = in_a[i] & in_b[i];
    assign or_y[i]  = in_a[i] | in_b[i];
    assign xor_y[i] = in_a[i] ^ in_b[i];
  end

endmodule

// File: rtl/int_alu_core.sv
`timescale 1ns/1ps
module int_alu_core
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [OP_W-1:0]   op_sel,
  output logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ZERO_W = '0;
  localparam logic [HALF_W-1:0] ZERO_H = '0;

  logic              sub_sel;
  logic [DATA_W-1:0] arith_y;
  logic [DATA_W-1:0] and_y;
  logic [DATA_W-1:0] or_y;
  logic [DATA_W-1:0] xor_y;
  logic [DATA_W-1:0] hi_y;
  rel_flags_t        rel;
  logic              set_bit;
  logic              is_set;

  assign sub_sel = (op_sel == OP_SUB);

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .in_a   (opnd_a),
    .in_b   (opnd_b),
    .do_sub (sub_sel),
    .sum    (arith_y)
  );

  alu_relcmp #(.DATA_W(DATA_W)) u_relcmp (
    .in_a  (opnd_a),
    .in_b  (opnd_b),
    .flags (rel)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .in_a  (opnd_a),
    .in_b  (opnd_b),
    .and_y (and_y),
    .or_y  (or_y),
    .xor_y (xor_y)
  );

  assign hi_y = {opnd_b[HALF_W-1:0], ZERO_H};

  // Relation selected into one bit, then widened to a boolean word.
  always_comb begin
    is_set  = 1'b1;
    set_bit = 1'b0;
    case (op_sel)
      OP_SLT:  set_bit = rel.lt;
      OP_SGT:  set_bit = ~rel.lt & ~rel.eq;
      OP_SLE:  set_bit = rel.lt | rel.eq;
      OP_SGE:  set_bit = ~rel.lt;
      OP_SEQ:  set_bit = rel.eq;
      OP_SNE:  set_bit = ~rel.eq;
      default: is_set  = 1'b0;
    endcase
  end

  always_comb begin
    result = ZERO_W;
    if (is_set) begin
      result[0] = set_bit;
    end else begin
      case (op_sel)
        OP_ADD,
        OP_SUB:  result = arith_y;
        OP_AND:  result = and_y;
        OP_OR:   result = or_y;
        OP_XOR:  result = xor_y;
        OP_LHI:  result = hi_y;
        default: result = ZERO_W;
      endcase
    end
  end

endmodule

// File: rtl/int_alu_checker.sv
`timescale 1ns/1ps
module int_alu_checker
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] result
);

  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel, result})) begin
      if (op_sel == OP_ADD) begin
        p_add_wrap_r1: assert (result - opnd_b == opnd_a);
      end
      if (op_sel == OP_SUB) begin
        p_sub_wrap_r2: assert (result + opnd_b == opnd_a);
      end
      if (op_sel == OP_XOR) begin
        p_xor_undo_r3: assert ((result ^ opnd_b) == opnd_a);
      end
      if (op_sel == OP_LHI) begin
        p_hi_place_r4: assert (result[HALF_W-1:0] == '0 &&
                               result[DATA_W-1:HALF_W] == opnd_b[HALF_W-1:0]);
      end
      if (op_sel >= OP_SLT && op_sel <= OP_SNE) begin
        p_bool_word_r8: assert (result[DATA_W-1:1] == '0);
      end
      if (op_sel == OP_SEQ) begin
        p_equal_r7: assert (result[0] == (opnd_a == opnd_b));
      end
      if (op_sel == OP_SLT) begin
        p_less_r5: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)));
      end
      if (op_sel > OP_SNE) begin
        p_undef_zero_r9: assert (result == '0);
      end
    end
  end

endmodule

bind int_alu_core int_alu_checker #(.DATA_W(DATA_W)) u_alu_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .op_sel (op_sel),
  .result (result)
);

// File: tb/int_alu_core_tb.sv
`timescale 1ns/1ps
module int_alu_core_tb_top;

  localparam int W    = 6;
  localparam int HALF = W / 2;
  localparam int SPAN = 1 << W;
  localparam int MASK = SPAN - 1;
  localparam int WATCHDOG_CYC = 150000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [3:0]   op_sel;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int_alu_core #(.DATA_W(W)) dut_i (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .result (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int to_signed(input int v);
    return (v >= SPAN / 2) ? v - SPAN : v;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0:          return "R1";
      1:          return "R2";
      2, 3, 4:    return "R3";
      5:          return "R4";
      6, 7:       return "R5";
      8, 9:       return "R6";
      10, 11:     return "R7";
      default:    return "R9";
    endcase
  endfunction

  function automatic int model(input int op, input int a, input int b);
    int sa;
    int sb;
    sa = to_signed(a);
    sb = to_signed(b);
    case (op)
      0:  return (a + b) & MASK;
      1:  return (a - b + SPAN) & MASK;
      2:  return a & b;
      3:  return a | b;
      4:  return a ^ b;
      5:  return (b & ((1 << HALF) - 1)) << HALF;
      6:  return (sa <  sb) ? 1 : 0;
      7:  return (sa >  sb) ? 1 : 0;
      8:  return (sa <= sb) ? 1 : 0;
      9:  return (sa >= sb) ? 1 : 0;
      10: return (a == b) ? 1 : 0;
      11: return (a != b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               req, op_sel, opnd_a, opnd_b, got, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    opnd_a = '0;
    opnd_b = '0;
    op_sel = 4'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: zero inputs with add selected give a zero word (R1).
    check("R1", int'(result), 0);

    // R10: mid-cycle input change is reflected within the same cycle.
    @(posedge clk);
    op_sel = 4'd0; opnd_a = 6'd20; opnd_b = 6'd9;
    #1;
    opnd_b = 6'd30;
    #2;
    check("R10", int'(result), 50);
    op_sel = 4'd4;
    #1;
    check("R10", int'(result), 20 ^ 30);

    // Exhaustive sweep: every selector, every operand pair.
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          @(posedge clk);
          op_sel = op[3:0];
          opnd_a = a[W-1:0];
          opnd_b = b[W-1:0];
          @(negedge clk);
          check(tag_of(op), int'(result), model(op, a, b));
          if (op >= 6 && op <= 11) begin
            check("R8", int'(result) >> 1, 0);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule